// File: doc/BRIEF.md
# Radio transmit sequencing controller

This block sequences the transmission of one frame on a low-power radio. While nothing is queued it keeps the radio and power amplifier switched off in a sleep state. A transmit request wakes the radio through a settle phase of fixed length. The transmit phase then runs as four ordered steps: amplifier switch-on, synchronization preamble, payload bytes and amplifier ramp-down. The amplifier is therefore powered only while the frame is on the air.

After a frame the controller listens for an acknowledge inside a window that a hardware counter times. If the window closes without an acknowledge, it backs off and tries again. The backoff doubles after each failed attempt. When the last allowed attempt fails, the controller parks in a fault state until software clears it. The block does not modulate or store the payload. It only produces a strobe and a byte index that a neighbouring serializer uses to fetch each payload byte.

Top module: `radio_tx_seq`

## Requirements
- R1: After reset the controller sleeps with radio_en, pa_en, data_valid, done and fail all low.
- R2: A request seen in sleep or idle raises radio_en on the next cycle and holds pa_en low for exactly WAKE_CYC cycles (default 16) before the amplifier turns on. radio_en is low in every state outside wake and transmit.
- R3: pa_en is high for one contiguous window of 1 + PRE_CYC + length + END_CYC cycles (defaults 1 + 32 + length + 4). radio_en is high throughout that window, and both drop together when the window ends.
- R4: data_valid is high for exactly length cycles inside the amplifier window. On those cycles byte_idx counts 0, 1, ..., length-1 in consecutive cycles. The length is taken from tx_len in the cycle the request is recorded, so later changes of tx_len have no effect. A length of 0 produces no strobe, and the amplifier window is then 1 + PRE_CYC + END_CYC cycles.
- R5: An ack in any cycle of the listen window ends the attempt. done is then high for exactly one cycle, with radio_en low.
- R6: An ack outside the listen window is ignored: done stays low and the attempt still times out.
- R7: If no ack arrives in the ACK_CYC-cycle window (default 200), attempt k (k less than MAX_ATTEMPTS) is followed by a radio-off gap of ACK_CYC + BACKOFF_BASE*2^(k-1) cycles (defaults 264, 328, 456) before radio_en rises again.
- R8: When attempt MAX_ATTEMPTS (default 4) times out, fail rises ACK_CYC cycles after pa_en falls. fail stays high, with the radio off, until fault_clear is pulsed. On the cycle after fault_clear, fail and radio_en are low.
- R9: A request that arrives while the controller is busy is remembered with its length. It is started from idle or sleep without a new request: radio_en rises one cycle after done, or one cycle after the fault is cleared.
- R10: A successful ack resets the attempt count, so the next frame again gets MAX_ATTEMPTS attempts even if the previous frame needed retries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Transmit request, one-cycle pulse |
| tx_len | input | LEN_W | Payload length in bytes, taken with the request |
| ack | input | 1 | Acknowledge pulse from the receive path |
| fault_clear | input | 1 | Leaves the fault state |
| radio_en | output | 1 | Radio power enable |
| pa_en | output | 1 | Power amplifier enable |
| data_valid | output | 1 | One strobe per payload byte |
| byte_idx | output | LEN_W | Index of the strobed byte |
| done | output | 1 | One-cycle pulse on an acknowledged frame |
| fail | output | 1 | High while in the fault state |

## Verification
All outputs are decoded from registered state, so an input sampled at one edge shows up at the outputs one cycle later. radio_en, done and fail change in the cycle after the request, the ack or the fault_clear that caused them. The bench drives inputs and samples outputs on the falling clock edge. It measures the wake, amplifier, strobe and radio-off gap windows by counting falling edges from the first sample that shows the new state, and compares each count with a value computed from the parameters. For the one-cycle results (done, the restart after done, and the exit from fault), the bench looks at exactly the first and second falling edge after the stimulus.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

  typedef enum logic [3:0] {
    ST_SLEEP,
    ST_IDLE,
    ST_WAKE,
    ST_TX_START,
    ST_TX_PRE,
    ST_TX_DATA,
    ST_TX_END,
    ST_ACK_WAIT,
    ST_RETRY,
    ST_FAULT
  } rtx_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rtx_timer.sv
// Loadable down counter shared by every timed phase.
module rtx_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/rtx_backoff.sv
// Backoff length for the attempt just failed: base doubled per earlier failure.
module rtx_backoff #(
  parameter int ATT_W = 3,
  parameter int TMR_W = 10,
  parameter int BASE  = 64
) (
  input  logic [ATT_W-1:0] attempt,
  output logic [TMR_W-1:0] dur
);
  logic [31:0]      full;
  logic [ATT_W-1:0] shamt;

  always_comb begin
    shamt = (attempt == '0) ? '0 : attempt - ATT_W'(1);
    full  = 32'(BASE) << shamt;
    dur   = TMR_W'(full);
  end
endmodule

// File: rtl/radio_tx_seq.sv
module radio_tx_seq #(
  parameter int LEN_W        = 8,
  parameter int WAKE_CYC     = 16,
  parameter int PRE_CYC      = 32,
  parameter int END_CYC      = 4,
  parameter int ACK_CYC      = 200,
  parameter int BACKOFF_BASE = 64,
  parameter int MAX_ATTEMPTS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_req,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             ack,
  input  logic             fault_clear,
  output logic             radio_en,
  output logic             pa_en,
  output logic             data_valid,
  output logic [LEN_W-1:0] byte_idx,
  output logic             done,
  output logic             fail
);
  import rtx_pkg::*;

  localparam int BO_MAX  = BACKOFF_BASE << (MAX_ATTEMPTS - 1);
  localparam int LONGEST = max2(max2(max2(WAKE_CYC, PRE_CYC), max2(END_CYC, ACK_CYC)), BO_MAX);
  localparam int TMR_W   = $clog2(LONGEST + 1);
  localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);

  rtx_state_t       st_q, st_n;
  logic [LEN_W-1:0] len_q, pend_len_q, idx_q, acc_len;
  logic [ATT_W-1:0] att_q;
  logic             pend_q;
  logic             at_rest, accept, last_byte;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val, bo_dur;

  // Request acceptance: only from the two resting states.
  assign at_rest   = (st_q == ST_SLEEP) || (st_q == ST_IDLE);
  assign accept    = at_rest && (tx_req || pend_q);
  assign acc_len   = tx_req ? tx_len : pend_len_q;
  assign last_byte = (idx_q == len_q - LEN_W'(1));

  rtx_backoff #(
    .ATT_W (ATT_W),
    .TMR_W (TMR_W),
    .BASE  (BACKOFF_BASE)
  ) u_backoff (
    .attempt (att_q),
    .dur     (bo_dur)
  );

  rtx_timer #(
    .W (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // Next-state logic.
  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_SLEEP:    if (accept) st_n = ST_WAKE;
      ST_IDLE:     st_n = accept ? ST_WAKE : ST_SLEEP;
      ST_WAKE:     if (tmr_zero) st_n = ST_TX_START;
      ST_TX_START: st_n = ST_TX_PRE;
      ST_TX_PRE:   if (tmr_zero) st_n = (len_q == '0) ? ST_TX_END : ST_TX_DATA;
      ST_TX_DATA:  if (last_byte) st_n = ST_TX_END;
      ST_TX_END:   if (tmr_zero) st_n = ST_ACK_WAIT;
      ST_ACK_WAIT: begin
        if (ack)
          st_n = ST_IDLE;
        else if (tmr_zero)
          st_n = (att_q >= ATT_W'(MAX_ATTEMPTS)) ? ST_FAULT : ST_RETRY;
      end
      ST_RETRY:    if (tmr_zero) st_n = ST_WAKE;
      ST_FAULT:    if (fault_clear) st_n = ST_SLEEP;
      default:     st_n = ST_SLEEP;
    endcase
  end

  // Phase length for the state being entered; loaded on the entering edge.
  always_comb begin
    tmr_load = (st_n != st_q);
    unique case (st_n)
      ST_WAKE:     tmr_val = TMR_W'(WAKE_CYC - 1);
      ST_TX_PRE:   tmr_val = TMR_W'(PRE_CYC - 1);
      ST_TX_END:   tmr_val = TMR_W'(END_CYC - 1);
      ST_ACK_WAIT: tmr_val = TMR_W'(ACK_CYC - 1);
      ST_RETRY:    tmr_val = bo_dur - TMR_W'(1);
      default:     tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_SLEEP;
      len_q      <= '0;
      pend_q     <= 1'b0;
      pend_len_q <= '0;
      idx_q      <= '0;
      att_q      <= '0;
    end else begin
      st_q <= st_n;

      if (accept) begin
        len_q  <= acc_len;
        pend_q <= 1'b0;
      end else if (tx_req) begin
        pend_q     <= 1'b1;
        pend_len_q <= tx_len;
      end

      if (st_q == ST_TX_DATA)
        idx_q <= idx_q + LEN_W'(1);
      else if (st_n == ST_TX_DATA)
        idx_q <= '0;

      if (accept)
        att_q <= ATT_W'(1);
      else if (st_q == ST_RETRY && st_n == ST_WAKE)
        att_q <= att_q + ATT_W'(1);
      else if ((st_q == ST_ACK_WAIT && st_n == ST_IDLE) ||
               (st_q == ST_FAULT && st_n == ST_SLEEP))
        att_q <= '0;
    end
  end

  // Moore outputs decoded from the state register only.
  assign radio_en   = (st_q == ST_WAKE) || (st_q == ST_TX_START) || (st_q == ST_TX_PRE) ||
                      (st_q == ST_TX_DATA) || (st_q == ST_TX_END);
  assign pa_en      = (st_q == ST_TX_START) || (st_q == ST_TX_PRE) ||
                      (st_q == ST_TX_DATA) || (st_q == ST_TX_END);
  assign data_valid = (st_q == ST_TX_DATA);
  assign byte_idx   = idx_q;
  assign done       = (st_q == ST_IDLE);
  assign fail       = (st_q == ST_FAULT);
endmodule

// File: rtl/radio_tx_seq_chk.sv
module radio_tx_seq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             fault_clear,
  input logic             radio_en,
  input logic             pa_en,
  input logic             data_valid,
  input logic [LEN_W-1:0] byte_idx,
  input logic             done,
  input logic             fail
);
  // R3: amplifier only with radio powered
  p_pa_needs_radio_r3: assert property (@(posedge clk) disable iff (rst)
    pa_en |-> radio_en);

  // R3: radio and amplifier drop together
  p_pa_fall_radio_off_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(pa_en) |-> !radio_en);

  // R2: radio wakes before the amplifier turns on
  p_wake_before_pa_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(radio_en) |-> !pa_en);

  // R4: strobes only inside the amplifier window
  p_strobe_in_window_r4: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> pa_en);

  // R4: byte index steps by one across consecutive strobes
  p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
    (data_valid && $past(data_valid)) |-> (byte_idx == $past(byte_idx) + LEN_W'(1)));

  // R5: done lasts one cycle and comes with the radio off
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_radio_off_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !radio_en);

  // R8: fault holds until cleared, then leaves with the radio off
  p_fail_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fail && !fault_clear) |=> fail);
  p_fail_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (fail && fault_clear) |=> (!fail && !radio_en));
  p_fail_radio_off_r8: assert property (@(posedge clk) disable iff (rst)
    fail |-> (!radio_en && !done));
endmodule

bind radio_tx_seq radio_tx_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fault_clear (fault_clear),
  .radio_en    (radio_en),
  .pa_en       (pa_en),
  .data_valid  (data_valid),
  .byte_idx    (byte_idx),
  .done        (done),
  .fail        (fail)
);

// File: tb/radio_tx_seq_bench.sv
`timescale 1ns/1ps
module radio_tx_seq_bench;
  localparam int LEN_W = 8;
  localparam int WAKE  = 16;
  localparam int PRE   = 32;
  localparam int ENDC  = 4;
  localparam int ACKC  = 200;
  localparam int BASE  = 64;
  localparam int MAXA  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tx_req = 1'b0;
  logic [LEN_W-1:0] tx_len = '0;
  logic             ack = 1'b0;
  logic             fault_clear = 1'b0;
  logic             radio_en, pa_en, data_valid, done, fail;
  logic [LEN_W-1:0] byte_idx;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  radio_tx_seq #(
    .LEN_W(LEN_W), .WAKE_CYC(WAKE), .PRE_CYC(PRE), .END_CYC(ENDC),
    .ACK_CYC(ACKC), .BACKOFF_BASE(BASE), .MAX_ATTEMPTS(MAXA)
  ) u_radio_tx_seq (
    .clk(clk), .rst(rst), .tx_req(tx_req), .tx_len(tx_len), .ack(ack),
    .fault_clear(fault_clear), .radio_en(radio_en), .pa_en(pa_en),
    .data_valid(data_valid), .byte_idx(byte_idx), .done(done), .fail(fail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic request(input int len);
    @(negedge clk);
    tx_req = 1'b1;
    tx_len = LEN_W'(len);
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  // Counts wake, amplifier and strobe cycles; returns on the first listen cycle.
  task automatic observe_frame(output int wk, output int pa, output int dv, output int bad);
    int guard;
    wk = 0; pa = 0; dv = 0; bad = 0; guard = 0;
    while (!radio_en && guard < 2000) begin @(negedge clk); guard++; end
    while (radio_en && !pa_en && guard < 4000) begin wk++; @(negedge clk); guard++; end
    while (pa_en && guard < 8000) begin
      if (!radio_en) bad++;
      if (data_valid) begin
        if (int'(byte_idx) != dv) bad++;
        dv++;
      end
      pa++;
      @(negedge clk);
      guard++;
    end
  endtask

  // Counts radio-off cycles starting at the current sample.
  task automatic count_gap(output int gap);
    gap = 0;
    while (!radio_en && !fail && gap < 5000) begin gap++; @(negedge clk); end
  endtask

  task automatic send_ack_and_check(input string req);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check(done === 1'b1 && radio_en === 1'b0, req, done, 1);
    @(negedge clk);
    check(done === 1'b0, req, done, 0);
  endtask

  task automatic t_reset;
    check({radio_en, pa_en, data_valid, done, fail} === 5'b0, "R1",
          {radio_en, pa_en, data_valid, done, fail}, 0);
  endtask

  task automatic t_basic;
    int wk, pa, dv, bad;
    ack = 1'b1;                      // ack while sleeping is ignored
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
    check(done === 1'b0 && radio_en === 1'b0, "R6", done, 0);
    request(5);
    tx_len = 8'd40;                  // change after acceptance has no effect
    observe_frame(wk, pa, dv, bad);
    check(wk == WAKE, "R2", wk, WAKE);
    check(pa == 1 + PRE + 5 + ENDC, "R3", pa, 1 + PRE + 5 + ENDC);
    check(dv == 5 && bad == 0, "R4", dv, 5);
    check(radio_en === 1'b0, "R2", radio_en, 0);
    repeat (9) @(negedge clk);
    send_ack_and_check("R5");
    check(radio_en === 1'b0, "R5", radio_en, 0);
  endtask

  task automatic t_zero_len;
    int wk, pa, dv, bad;
    request(0);
    observe_frame(wk, pa, dv, bad);
    check(pa == 1 + PRE + ENDC, "R4", pa, 1 + PRE + ENDC);
    check(dv == 0, "R4", dv, 0);
    send_ack_and_check("R5");
  endtask

  task automatic t_pending;
    int wk, pa, dv, bad;
    request(6);
    tx_req = 1'b1;                   // arrives while waking: held
    tx_len = 8'd3;
    @(negedge clk);
    tx_req = 1'b0;
    tx_len = 8'd9;
    observe_frame(wk, pa, dv, bad);
    check(dv == 6 && bad == 0, "R4", dv, 6);
    send_ack_and_check("R5");
    check(radio_en === 1'b1, "R9", radio_en, 1);
    observe_frame(wk, pa, dv, bad);
    check(dv == 3 && bad == 0, "R9", dv, 3);
    send_ack_and_check("R5");
  endtask

  task automatic t_retry_success;
    int wk, pa, dv, bad, gap;
    request(2);
    observe_frame(wk, pa, dv, bad);
    count_gap(gap);
    check(gap == ACKC + BASE, "R7", gap, ACKC + BASE);
    observe_frame(wk, pa, dv, bad);
    check(wk == WAKE && dv == 2, "R7", wk, WAKE);
    send_ack_and_check("R5");
  endtask

  task automatic t_fault;
    int wk, pa, dv, bad, gap;
    request(2);
    ack = 1'b1;                      // ack while waking is ignored
    @(negedge clk);
    ack = 1'b0;
    observe_frame(wk, pa, dv, bad);
    count_gap(gap);
    check(gap == ACKC + BASE, "R6", gap, ACKC + BASE);
    for (int k = 2; k <= MAXA; k++) begin
      observe_frame(wk, pa, dv, bad);
      count_gap(gap);
      if (k < MAXA)
        check(gap == ACKC + (BASE << (k - 1)), "R7", gap, ACKC + (BASE << (k - 1)));
      else
        check(gap == ACKC && fail === 1'b1, "R10", gap, ACKC);
    end
    check(fail === 1'b1, "R8", fail, 1);
    tx_req = 1'b1;                   // held pending during fault
    tx_len = 8'd1;
    ack = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    ack = 1'b0;
    repeat (20) @(negedge clk);
    check(fail === 1'b1 && radio_en === 1'b0, "R8", fail, 1);
    fault_clear = 1'b1;
    @(negedge clk);
    fault_clear = 1'b0;
    check(fail === 1'b0 && radio_en === 1'b0, "R8", fail, 0);
    @(negedge clk);
    check(radio_en === 1'b1, "R9", radio_en, 1);
    observe_frame(wk, pa, dv, bad);
    check(dv == 1 && bad == 0, "R9", dv, 1);
    send_ack_and_check("R5");
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero_len();
    t_pending();
    t_retry_success();
    t_fault();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule